// File: doc/BRIEF.md
# Stop-Clock Request Handshake Controller

This block takes an active-low, asynchronous request to stop the processor clock and turns it into an orderly stop sequence. The request is first brought into the core clock domain through a synchronizer. Once the request is recognised, the block waits for the next instruction boundary. A pending interrupt of higher priority takes that boundary instead. Otherwise the block halts execution, tells the core to empty its pipelines and write buffers, and, once they report empty, asks the bus unit to issue the stop-grant special bus cycle. When that cycle is acknowledged with either ready signal, the block reports that the core has stopped.

The controller stays stopped for as long as the request is held. When the request is released, execution resumes on the cycle after the synchronized release. If the request goes away before any boundary has been accepted, the block drops back to idle without stopping. It does not gate the clock and it does not encode the bus cycle. The grant request is a plain level that the bus unit holds until it returns ready, so this edge has no back-pressure beyond that wait.

Top module: `stopclk_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, halt_exec, drain_cmd, grant_req and stopped are all low.
- R2: A low level on stop_req_n first takes effect on the third rising edge after it is applied (two synchronizer stages plus the state register), so an instruction boundary seen at the second edge or earlier causes no halt.
- R3: While a recognised request waits, an edge with insn_boundary high and irq_pending low raises halt_exec and drain_cmd. At an edge with irq_pending high the request stays pending and halt_exec stays low.
- R4: halt_exec is high from the first drain cycle through the whole stopped period.
- R5: drain_cmd stays high until pipe_empty is seen high, and grant_req rises only on the edge after pipe_empty was high.
- R6: grant_req stays high until bus_rdy or bus_brdy (both active high) is seen high, and either one completes the grant. A ready seen outside the grant phase has no effect.
- R7: stopped rises on the edge after the acknowledged grant and stays high while the request stays asserted.
- R8: When stop_req_n goes high during the stopped phase, all outputs go low on the third rising edge after the release.
- R9: A request that is released while it waits for a boundary returns the block to idle without halting. A release wins over a boundary seen on the same edge.
- R10: insn_boundary has no effect while no request has been recognised.
- R11: At most one of drain_cmd, grant_req and stopped is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop-clock request |
| insn_boundary | input | 1 | High for one cycle at each instruction boundary |
| irq_pending | input | 1 | Interrupt of higher priority is pending |
| pipe_empty | input | 1 | Pipelines and write buffers are empty |
| bus_rdy | input | 1 | Single-transfer ready, active high |
| bus_brdy | input | 1 | Burst ready, active high |
| halt_exec | output | 1 | Execution must stop |
| drain_cmd | output | 1 | Empty pipelines and write buffers |
| grant_req | output | 1 | Issue the stop-grant special bus cycle |
| stopped | output | 1 | Stop sequence complete |

## Verification
The assertions assume that the system holds stop_req_n low from the moment draining starts until the grant has been acknowledged. They also assume that ready is returned only in response to the grant. Every stimulus sequence releases the request only while waiting or after stopped is high, so the check that the request is held never sees a protocol breach. Inputs change on the falling edge, which keeps the synchronizer latency at exactly two edges and makes the expected cycle of every output change fixed.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

  typedef enum logic [2:0] {
    SC_IDLE    = 3'd0,
    SC_WAIT    = 3'd1,
    SC_DRAIN   = 3'd2,
    SC_GRANT   = 3'd3,
    SC_STOPPED = 3'd4
  } sc_state_e;

endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("stopclk_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[LAST-1:0], din};
  end

  assign dout = chain[LAST];

endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
  import stopclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  logic      boundary,
  input  logic      irq_pending,
  input  logic      drained,
  input  logic      bus_ack,
  output sc_state_e state
);

  sc_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      SC_IDLE:    if (req) nxt = SC_WAIT;
      SC_WAIT: begin
        if (!req)                          nxt = SC_IDLE;
        else if (boundary && !irq_pending) nxt = SC_DRAIN;
      end
      SC_DRAIN:   if (drained) nxt = SC_GRANT;
      SC_GRANT:   if (bus_ack) nxt = SC_STOPPED;
      SC_STOPPED: if (!req)    nxt = SC_IDLE;
      default:    nxt = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SC_IDLE;
    else        state <= nxt;
  end

  AST_BOUNDARY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SC_WAIT && req && boundary && !irq_pending) |=> state == SC_DRAIN); // R3
  AST_IRQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SC_WAIT && req && irq_pending) |=> state == SC_WAIT); // R3
  AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SC_WAIT && !req) |=> state == SC_IDLE); // R9
  AST_IDLE_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SC_IDLE) |=> (state == SC_IDLE || state == SC_WAIT)); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SC_DRAIN || state == SC_GRANT) |-> req); // R6

endmodule

// File: rtl/stopclk_outdec.sv
module stopclk_outdec
  import stopclk_pkg::*;
(
  input  sc_state_e state,
  output logic      halt_exec,
  output logic      drain_cmd,
  output logic      grant_req,
  output logic      stopped
);

  always_comb begin
    halt_exec = 1'b0;
    drain_cmd = 1'b0;
    grant_req = 1'b0;
    stopped   = 1'b0;
    unique case (state)
      SC_DRAIN:   begin halt_exec = 1'b1; drain_cmd = 1'b1; end
      SC_GRANT:   begin halt_exec = 1'b1; grant_req = 1'b1; end
      SC_STOPPED: begin halt_exec = 1'b1; stopped   = 1'b1; end
      default:    ;
    endcase
  end

endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
  import stopclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req_n,
  input  logic insn_boundary,
  input  logic irq_pending,
  input  logic pipe_empty,
  input  logic bus_rdy,
  input  logic bus_brdy,
  output logic halt_exec,
  output logic drain_cmd,
  output logic grant_req,
  output logic stopped
);

  logic      req_sync_n;
  logic      stop_req;
  logic      bus_ack;
  sc_state_e state;

  stopclk_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (stop_req_n),
    .dout (req_sync_n)
  );

  assign stop_req = ~req_sync_n;
  assign bus_ack  = bus_rdy | bus_brdy;

  stopclk_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (stop_req),
    .boundary   (insn_boundary),
    .irq_pending(irq_pending),
    .drained    (pipe_empty),
    .bus_ack    (bus_ack),
    .state      (state)
  );

  stopclk_outdec u_dec (
    .state    (state),
    .halt_exec(halt_exec),
    .drain_cmd(drain_cmd),
    .grant_req(grant_req),
    .stopped  (stopped)
  );

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drain_cmd, grant_req, stopped})); // R11
  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_exec) |-> drain_cmd); // R4
  AST_NO_EARLY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_req) |-> $past(pipe_empty)); // R5
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_cmd && !pipe_empty) |=> drain_cmd); // R5
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_req && !(bus_rdy || bus_brdy)) |=> grant_req); // R6
  AST_GRANT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_req && (bus_rdy || bus_brdy)) |=> stopped); // R7
  AST_STOP_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> halt_exec); // R4

endmodule

// File: tb/sim_stopclk_ctrl.sv
module sim_stopclk_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req_n = 1'b1;
  logic insn_boundary = 1'b0;
  logic irq_pending = 1'b0;
  logic pipe_empty = 1'b0;
  logic bus_rdy = 1'b0;
  logic bus_brdy = 1'b0;
  logic halt_exec, drain_cmd, grant_req, stopped;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  stopclk_ctrl #(.SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n),
    .insn_boundary(insn_boundary), .irq_pending(irq_pending),
    .pipe_empty(pipe_empty), .bus_rdy(bus_rdy), .bus_brdy(bus_brdy),
    .halt_exec(halt_exec), .drain_cmd(drain_cmd),
    .grant_req(grant_req), .stopped(stopped)
  );

  // {req_n, boundary, irq, empty, rdy, brdy, halt, drain, grant, stopped}
  localparam int NV = 31;
  localparam logic [9:0] VEC [NV] = '{
    10'b1_1_0_0_0_0_0000, // 0  R10 boundary while idle
    10'b0_0_0_0_0_0_0000, // 1  R2
    10'b0_1_0_0_0_0_0000, // 2  R2 boundary before recognition
    10'b0_1_0_0_0_0_0000, // 3  R2 recognised, waiting
    10'b0_1_1_0_0_0_0000, // 4  R3 interrupt wins
    10'b0_1_0_0_0_0_1100, // 5  R3 halt and drain
    10'b0_0_0_0_1_0_1100, // 6  R6 ready while draining ignored
    10'b0_0_0_1_0_0_1010, // 7  R5 empty -> grant
    10'b0_0_0_1_0_0_1010, // 8  R6 grant held
    10'b0_0_0_0_0_1_1001, // 9  R6 burst ready ends grant
    10'b0_1_0_0_0_0_1001, // 10 R7
    10'b1_0_0_0_0_0_1001, // 11 R8
    10'b1_0_0_0_0_0_1001, // 12 R8
    10'b1_0_0_0_0_0_0000, // 13 R8 resume
    10'b0_0_0_0_0_0_0000, // 14
    10'b0_0_0_0_0_0_0000, // 15
    10'b0_0_0_0_0_0_0000, // 16 waiting
    10'b1_0_0_0_0_0_0000, // 17 R9
    10'b1_0_0_0_0_0_0000, // 18 R9
    10'b1_1_0_0_0_0_0000, // 19 R9 release beats boundary
    10'b1_1_0_0_0_0_0000, // 20 R10
    10'b0_0_0_0_0_0_0000, // 21
    10'b0_0_0_0_0_0_0000, // 22
    10'b0_0_0_0_0_0_0000, // 23 waiting
    10'b0_1_0_1_0_0_1100, // 24 R3
    10'b0_0_0_1_0_0_1010, // 25 R5
    10'b0_0_0_0_1_0_1001, // 26 R6 single ready ends grant
    10'b0_0_0_0_0_0_1001, // 27 R7
    10'b1_0_0_0_0_0_1001, // 28 R8
    10'b1_0_0_0_0_0_1001, // 29 R8
    10'b1_0_0_0_0_0_0000  // 30 R8
  };
  localparam int TAG [NV] = '{10,2,2,2,3,3,6,5,6,6,7,8,8,8,2,2,2,9,9,9,10,
                              2,2,2,3,5,6,7,8,8,8};

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s outputs=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {halt_exec, drain_cmd, grant_req, stopped};
  endfunction

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", outs(), 4'b0000);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", outs(), 4'b0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {stop_req_n, insn_boundary, irq_pending, pipe_empty, bus_rdy, bus_brdy} = VEC[i][9:4];
      @(posedge clk); #1;
      check($sformatf("R%0d vec%0d", TAG[i], i), outs(), VEC[i][3:0]);
    end

    // Directed: reset in the middle of a drain, then re-synchronise.
    @(negedge clk);
    stop_req_n = 1'b0; insn_boundary = 1'b1; irq_pending = 1'b0;
    pipe_empty = 1'b0; bus_rdy = 1'b0; bus_brdy = 1'b0;
    repeat (4) @(posedge clk);
    #1 check("R3 pre-reset drain", outs(), 4'b1100);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 async reset", outs(), 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R2 sync latency", outs(), 4'b0000);
    @(posedge clk); #1;
    check("R2 third edge waits", outs(), 4'b0000);
    @(posedge clk); #1;
    check("R3 halt after boundary", outs(), 4'b1100);
    @(negedge clk);
    insn_boundary = 1'b0; pipe_empty = 1'b1;
    @(posedge clk); #1;
    check("R5 grant after empty", outs(), 4'b1010);
    @(negedge clk);
    pipe_empty = 1'b0; bus_rdy = 1'b1; bus_brdy = 1'b1;
    @(posedge clk); #1;
    check("R7 stopped", outs(), 4'b1001);
    @(negedge clk);
    bus_rdy = 1'b0; bus_brdy = 1'b0; stop_req_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R8 still stopped", outs(), 4'b1001);
    @(posedge clk); #1;
    check("R8 resumed", outs(), 4'b0000);

    finish_run();
  end

endmodule